// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter with Break and Idle Frames

This block serialises host data onto a single asynchronous line. It sends three kinds of frame: data frames, idle frames and break frames. A data frame holds one low start bit, 8 or 9 data bits sent least significant bit first, and one high stop bit. When parity is on, the top data position carries an even or odd parity bit in place of the most significant data bit. An idle frame keeps the line high for one full frame time. A break frame holds the line low for one full frame time.

After a break, the block puts a single high guard bit on the line before any frame that is not another break. This lets a receiver see the next start edge.

Timing comes only from a transmit bit-rate enable pulse. The line advances by one bit position on each pulse. A host writes a data word into a one-entry holding register and can post idle or break requests at any time. Requests that are pending together are served in a fixed order. Frames follow each other with no gap.

Top module: `sft_tx`

## Requirements
- R1: During and directly after reset, `tx_line` is high, `tx_busy` is low and `tx_empty` is high.
- R2: A data frame is a 0 start bit, then the data bits LSB first, then a 1 stop bit. Its length is 10 bit times when `cfg_nine`=0 and 11 when `cfg_nine`=1. The line changes only on a `baud_tick` edge, one bit per tick.
- R3: With `cfg_par_en`=1, the top data position (bit 7 in 8-bit mode, bit 8 in 9-bit mode) carries parity over the data bits below it. With `cfg_par_odd`=0 the parity makes the count of ones even; with `cfg_par_odd`=1 it makes the count odd.
- R4: An idle frame is one frame length of 1 bits. A queued data frame's start bit follows it on the very next tick.
- R5: A break frame is one frame length of 0 bits.
- R6: After a break frame, exactly one 1 bit goes out before the start of a following non-break frame.
- R7: Requests pending together are served break first, then idle, then data. A request posted during a frame waits until that frame ends. The holding register is released only on a tick.
- R8: `tx_empty` is high while the holding register is free and falls only after a write. A write while it is full is ignored and does not replace the held word.
- R9: `tx_busy` is high while a frame or guard bit is on the line, rises only on a tick, and is low with the line high once nothing is left to send.
- R10: A data word written during a frame is sent with its start bit on the tick directly after the current stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | Transmit bit-rate enable, one pulse per bit time |
| cfg_nine | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| cfg_par_en | input | 1 | Parity replaces the top data bit |
| cfg_par_odd | input | 1 | 1 odd parity, 0 even parity |
| wr_vld | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Word to send (bit 8 used in 9-bit mode) |
| req_idle | input | 1 | Pulse: queue one idle frame |
| req_break | input | 1 | Pulse: queue one break frame |
| tx_line | output | 1 | Serial output |
| tx_busy | output | 1 | Frame or guard bit in progress |
| tx_empty | output | 1 | Holding register can accept a word |

## Verification
The bench captures the line bit by bit on each tick and compares whole bit streams. This exposes several faults:
- A design that reverses the bit order, miscounts the frame length or inverts the parity sense fails the data frame checks in both word lengths.
- A missing or doubled guard bit after a break shifts the next start bit by one position.
- Requests posted in the same cycle check the service order. An order that serves data before break or idle shows a start bit where a run of zeros or ones was expected.
- A second write while the holding register is full checks that the first word is not overwritten.
- A word written in mid-frame must start right after the stop bit. A design that adds an idle bit between frames fails this check.

// File: rtl/sft_pkg.sv
// Package: shared widths and frame kind encoding for the serial frame transmitter.
// Assumes at most 9 data bits; the frame adds a start and a stop bit.
package sft_pkg;
    localparam int DATA_W  = 9;
    localparam int FRAME_W = DATA_W + 2;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef enum logic [2:0] {
        FK_NONE,
        FK_DATA,
        FK_IDLE,
        FK_BRK,
        FK_GUARD
    } frame_kind_t;
endpackage

// File: rtl/sft_hold.sv
// Holding register and request flags.
// Keeps one data word and the pending idle/break requests until the
// sequencer claims them. A write is accepted only while the slot is free.
module sft_hold #(
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_vld,
    input  logic [DW-1:0] wr_data,
    input  logic          req_idle,
    input  logic          req_break,
    input  logic          take_data,
    input  logic          take_idle,
    input  logic          take_brk,
    output logic [DW-1:0] data_q,
    output logic          data_full,
    output logic          idle_pend,
    output logic          brk_pend
);
    // Data slot: fill when free, release when the sequencer loads it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_full <= 1'b0;
            data_q    <= '0;
        end else if (take_data) begin
            data_full <= 1'b0;
        end else if (wr_vld && !data_full) begin
            data_full <= 1'b1;
            data_q    <= wr_data;
        end
    end

    // Request flags: a new pulse wins over a same-cycle claim.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_pend <= 1'b0;
            brk_pend  <= 1'b0;
        end else begin
            idle_pend <= (idle_pend && !take_idle) || req_idle;
            brk_pend  <= (brk_pend && !take_brk) || req_break;
        end
    end
endmodule

// File: rtl/sft_frame.sv
// Data frame builder (combinational).
// Produces the LSB-first bit vector of a data frame: start, data, optional
// parity in the top data position, stop. Positions past the stop bit are 1.
module sft_frame #(
    parameter int DW = 9,
    localparam int FW = DW + 2
) (
    input  logic [DW-1:0] data,
    input  logic          nine,
    input  logic          par_en,
    input  logic          par_odd,
    output logic [FW-1:0] vec
);
    localparam int TOP_LONG  = DW - 1;
    localparam int TOP_SHORT = DW - 2;

    int   top;
    logic par;

    // Assemble the frame and fold the parity over the bits below the top one.
    always_comb begin
        top    = nine ? TOP_LONG : TOP_SHORT;
        vec    = '1;
        vec[0] = 1'b0;
        par    = par_odd;
        for (int i = 0; i < DW; i++) begin
            if (i < top) begin
                vec[i+1] = data[i];
                par      = par ^ data[i];
            end else if (i == top) begin
                vec[i+1] = par_en ? par : data[i];
            end
        end
    end
endmodule

// File: rtl/sft_seq.sv
// Frame sequencer.
// On each bit-rate tick it either moves to the next bit of the current
// frame or, at the end of the last bit, picks the next frame. The order is:
// guard bit after a break, then break, then idle, then data.
// Frame length and format are sampled when a frame is loaded.
module sft_seq
    import sft_pkg::*;
#(
    parameter int DW = 9,
    localparam int FW = DW + 2,
    localparam int CW = $clog2(FW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          nine,
    input  logic [FW-1:0] data_vec,
    input  logic          data_full,
    input  logic          idle_pend,
    input  logic          brk_pend,
    output logic          take_data,
    output logic          take_idle,
    output logic          take_brk,
    output logic          line,
    output logic          busy
);
    localparam logic [CW-1:0] LEN_SHORT = CW'(DW + 1);
    localparam logic [CW-1:0] LEN_LONG  = CW'(DW + 2);

    logic          active;
    logic [FW-1:0] sr;
    logic [CW-1:0] cnt;
    frame_kind_t   kind;

    logic          at_end;
    frame_kind_t   next_kind;
    logic [CW-1:0] frame_len;

    // Choose what starts when the current bit ends.
    always_comb begin
        at_end    = baud_tick && (!active || cnt == CW'(1));
        frame_len = nine ? LEN_LONG : LEN_SHORT;
        next_kind = FK_NONE;
        if (active && kind == FK_BRK && !brk_pend) next_kind = FK_GUARD;
        else if (brk_pend)                         next_kind = FK_BRK;
        else if (idle_pend)                        next_kind = FK_IDLE;
        else if (data_full)                        next_kind = FK_DATA;
        take_brk  = at_end && next_kind == FK_BRK;
        take_idle = at_end && next_kind == FK_IDLE;
        take_data = at_end && next_kind == FK_DATA;
    end

    // Advance the bit position or load the next frame on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            sr     <= '1;
            cnt    <= '0;
            kind   <= FK_NONE;
        end else if (baud_tick) begin
            if (!at_end) begin
                sr  <= {1'b1, sr[FW-1:1]};
                cnt <= cnt - CW'(1);
            end else begin
                kind <= next_kind;
                unique case (next_kind)
                    FK_GUARD: begin active <= 1'b1; sr <= '1;       cnt <= CW'(1);    end
                    FK_BRK:   begin active <= 1'b1; sr <= '0;       cnt <= frame_len; end
                    FK_IDLE:  begin active <= 1'b1; sr <= '1;       cnt <= frame_len; end
                    FK_DATA:  begin active <= 1'b1; sr <= data_vec; cnt <= frame_len; end
                    default:  begin active <= 1'b0; sr <= '1;       cnt <= '0;        end
                endcase
            end
        end
    end

    assign line = active ? sr[0] : 1'b1;
    assign busy = active;
endmodule

// File: rtl/sft_tx.sv
// Top: asynchronous serial frame transmitter with idle and break frames.
// Assumes baud_tick is a single-cycle enable from a dedicated transmit
// bit-rate generator; all logic runs on clk with synchronous active-low reset.
module sft_tx
    import sft_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              cfg_nine,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              wr_vld,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              req_idle,
    input  logic              req_break,
    output logic              tx_line,
    output logic              tx_busy,
    output logic              tx_empty
);
    logic [DATA_W-1:0]  data_q;
    logic [FRAME_W-1:0] data_vec;
    logic data_full, idle_pend, brk_pend;
    logic take_data, take_idle, take_brk;

    sft_hold #(.DW(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_vld    (wr_vld),
        .wr_data   (wr_data),
        .req_idle  (req_idle),
        .req_break (req_break),
        .take_data (take_data),
        .take_idle (take_idle),
        .take_brk  (take_brk),
        .data_q    (data_q),
        .data_full (data_full),
        .idle_pend (idle_pend),
        .brk_pend  (brk_pend)
    );

    sft_frame #(.DW(DATA_W)) u_frame (
        .data    (data_q),
        .nine    (cfg_nine),
        .par_en  (cfg_par_en),
        .par_odd (cfg_par_odd),
        .vec     (data_vec)
    );

    sft_seq #(.DW(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .nine      (cfg_nine),
        .data_vec  (data_vec),
        .data_full (data_full),
        .idle_pend (idle_pend),
        .brk_pend  (brk_pend),
        .take_data (take_data),
        .take_idle (take_idle),
        .take_brk  (take_brk),
        .line      (tx_line),
        .busy      (tx_busy)
    );

    assign tx_empty = !data_full;
endmodule

// File: rtl/sft_tx_chk.sv
// Checker: port-level temporal properties of sft_tx, bound to every instance.
module sft_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic baud_tick,
    input logic wr_vld,
    input logic tx_line,
    input logic tx_busy,
    input logic tx_empty
);
    // Reset leaves the line idle and the holding register free.
    assert_reset_idle_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (tx_line && !tx_busy && tx_empty));

    // The line moves only on a bit-rate tick.
    assert_line_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(baud_tick) |-> $stable(tx_line));

    // Busy rises only on a tick.
    assert_busy_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> $past(baud_tick));

    // The holding register fills only after a write.
    assert_fill_by_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_empty) |-> $past(wr_vld));

    // A write while full, off a tick, leaves the register full.
    assert_full_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_empty && wr_vld && !baud_tick) |=> !tx_empty);

    // The held word is claimed only on a tick.
    assert_claim_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_empty) |-> $past(baud_tick));
endmodule

bind sft_tx sft_tx_chk u_sft_tx_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .wr_vld    (wr_vld),
    .tx_line   (tx_line),
    .tx_busy   (tx_busy),
    .tx_empty  (tx_empty)
);

// File: tb/tb_sft_tx.sv
module tb_sft_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick;
    logic       cfg_nine = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic       wr_vld = 1'b0;
    logic [8:0] wr_data = '0;
    logic       req_idle = 1'b0, req_break = 1'b0;
    logic       tx_line, tx_busy, tx_empty;
    logic [1:0] tc;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    // Tick on every fourth clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            tc <= '0;
            baud_tick <= 1'b0;
        end else begin
            tc <= tc + 2'd1;
            baud_tick <= (tc == 2'd2);
        end
    end

    sft_tx dut (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Wait until just after the next tick edge.
    task automatic sync();
        do @(negedge clk); while (!baud_tick);
        @(negedge clk);
    endtask

    task automatic grab(input int n, output logic [63:0] v);
        v = '0;
        for (int i = 0; i < n; i++) begin
            sync();
            v[i] = tx_line;
        end
    endtask

    function automatic int flen(bit nine);
        return nine ? 11 : 10;
    endfunction

    // Expected data frame bits, LSB first.
    function automatic logic [63:0] frame(logic [8:0] d, bit nine, bit pe, bit po);
        logic [63:0] v = '0;
        int nd = nine ? 9 : 8;
        logic p = po;
        for (int i = 0; i < nd; i++) v[i+1] = d[i];
        if (pe) begin
            for (int i = 0; i < nd - 1; i++) p ^= d[i];
            v[nd] = p;
        end
        v[nd+1] = 1'b1;
        return v;
    endfunction

    function automatic logic [63:0] ones(int n);
        return (64'd1 << n) - 64'd1;
    endfunction

    task automatic pulse(input bit w, input logic [8:0] d, input bit idl, input bit brk);
        wr_vld = w; wr_data = d; req_idle = idl; req_break = brk;
        @(negedge clk);
        wr_vld = 1'b0; req_idle = 1'b0; req_break = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 line", {63'd0, tx_line}, 64'd1);
        check("R1 busy", {63'd0, tx_busy}, 64'd0);
        check("R1 empty", {63'd0, tx_empty}, 64'd1);
    endtask

    task automatic t_data(input logic [8:0] d, input bit nine, input bit pe, input bit po, input string tag);
        logic [63:0] v;
        cfg_nine = nine; cfg_par_en = pe; cfg_par_odd = po;
        sync();
        pulse(1'b1, d, 1'b0, 1'b0);
        grab(flen(nine), v);
        check(tag, v, frame(d, nine, pe, po));
        check("R8 empty after claim", {63'd0, tx_empty}, 64'd1);
    endtask

    task automatic t_idle_data();
        logic [63:0] v;
        int n = flen(1'b0);
        cfg_nine = 0; cfg_par_en = 0;
        sync();
        pulse(1'b1, 9'h0C4, 1'b1, 1'b0);
        grab(2 * n, v);
        check("R4 R7 idle then data", v, ones(n) | (frame(9'h0C4, 0, 0, 0) << n));
    endtask

    task automatic t_break_data();
        logic [63:0] v;
        int n = flen(1'b1);
        cfg_nine = 1; cfg_par_en = 0;
        sync();
        pulse(1'b1, 9'h155, 1'b0, 1'b1);
        grab(2 * n + 1, v);
        check("R5 R6 break guard data", v, (64'd1 << n) | (frame(9'h155, 1, 0, 0) << (n + 1)));
    endtask

    task automatic t_priority();
        logic [63:0] v;
        int n = flen(1'b0);
        cfg_nine = 0; cfg_par_en = 0;
        sync();
        pulse(1'b1, 9'h03C, 1'b1, 1'b1);
        grab(3 * n + 1, v);
        check("R7 break idle data order", v,
              (ones(n + 1) << n) | (frame(9'h03C, 0, 0, 0) << (2 * n + 1)));
    endtask

    task automatic t_full_ignore();
        logic [63:0] v;
        cfg_nine = 0; cfg_par_en = 0;
        sync();
        pulse(1'b1, 9'h0A1, 1'b0, 1'b0);
        check("R8 empty falls on write", {63'd0, tx_empty}, 64'd0);
        pulse(1'b1, 9'h05E, 1'b0, 1'b0);
        grab(flen(1'b0), v);
        check("R8 second write ignored", v, frame(9'h0A1, 0, 0, 0));
    endtask

    task automatic t_b2b();
        logic [63:0] v, w;
        int n = flen(1'b1);
        cfg_nine = 1; cfg_par_en = 1; cfg_par_odd = 0;
        sync();
        pulse(1'b1, 9'h0F0, 1'b0, 1'b0);
        grab(1, v);
        check("R9 busy in frame", {63'd0, tx_busy}, 64'd1);
        pulse(1'b1, 9'h18B, 1'b0, 1'b0);
        grab(2 * n - 1, w);
        v = v | (w << 1);
        check("R10 back to back", v, frame(9'h0F0, 1, 1, 0) | (frame(9'h18B, 1, 1, 0) << n));
        sync();
        sync();
        check("R9 busy low after", {63'd0, tx_busy}, 64'd0);
        check("R9 line high after", {63'd0, tx_line}, 64'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_data(9'h0A5, 0, 0, 0, "R2 8-bit frame");
        t_data(9'h1C3, 1, 0, 0, "R2 9-bit frame");
        t_data(9'h037, 0, 1, 0, "R3 8-bit even parity");
        t_data(9'h0B2, 1, 1, 1, "R3 9-bit odd parity");
        t_data(9'h000, 0, 1, 1, "R3 odd parity of zero");
        t_idle_data();
        t_break_data();
        t_priority();
        t_full_ignore();
        t_b2b();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule